// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns 32-bit device-side (IO) virtual addresses into physical addresses by walking a single-level page table that lives in system memory. Software programs a small word-addressed register window: a control word whose 3-bit range code sets where the IO window begins in the 32-bit space, and a table-base word that locates the page table. The window always ends at the top of the address space, and its size runs from 16 MB to 2 GB.

A device presents a virtual address on a valid/ready handshake. The block works out the address of the 4-byte table entry for that page and issues a single read on a simple memory port. The entry is stored big-endian, so the block byte-swaps it when it arrives, builds the physical address from the page field and the page offset, and presents the result for one cycle. An entry whose valid bit is clear still yields an address, and an error flag is raised with it. Only one translation is in flight at a time, and register writes are refused while it is.

Top module: `iova_xlate`

## Requirements
- R1: After reset the control register reads 0x0000001C (range code 7, a 2 GB window), every other register reads 0, tr_ready is 1, reg_ready is 1, and mem_req and res_valid are 0.
- R2: A register access hits register (reg_addr − BASE_ADDR) >> 2 when that value is below NUM_REGS. The two low address bits are ignored. A write stores the full 32-bit value, and reg_rdata returns the last value written. An address outside the window changes nothing and reads as 0.
- R3: The range code is control bits [4:2]. Code c sets the window start to 2^32 − 2^(24+c): 0 gives 0xFF000000 and 7 gives 0x80000000. Only a write to the control register changes the start.
- R4: The cycle after a translation is accepted (tr_valid and tr_ready both high at a clock edge), mem_req is high for exactly one cycle. mem_addr is then (register1 << 4) + (((vaddr − start) >> 12) << 2), taken modulo 2^32.
- R5: mem_rdata holds the entry with its most significant byte in bits [7:0]. The block reverses the byte order to form the entry E. In the cycle after mem_rvalid is sampled high, res_valid is high for one cycle and res_paddr is ((E & 0xFFFFFF00) << 4) modulo 2^32, plus vaddr[11:0].
- R6: res_err is 1 exactly when bit 1 of E, the valid flag, is 0. Bit 0 of E, a write-as-zero bit, has no effect on the result.
- R7: From acceptance until the cycle after the result, tr_ready and reg_ready are 0. A register write made during that time is ignored.
- R8: A mem_rvalid pulse that does not arrive while the block is waiting for the entry is ignored. This covers the idle state and the cycle in which the request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable for the register access |
| reg_addr | input | 32 | Register bus byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_ready | output | 1 | Register writes are accepted |
| tr_valid | input | 1 | Translation request valid |
| tr_ready | output | 1 | Translator idle, request accepted |
| tr_vaddr | input | 32 | IO virtual address to translate |
| mem_req | output | 1 | One-cycle read request for a table entry |
| mem_addr | output | 32 | Table entry byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Raw big-endian entry word |
| res_valid | output | 1 | Result valid, one cycle |
| res_paddr | output | 32 | Translated physical address |
| res_err | output | 1 | Entry valid bit was clear |

## Verification
The hardest case to reach from the ports is a register write, or a stray read-data pulse, that lands while a walk is in progress: the request cycle, the latency the memory chooses, and the bus activity all have to line up. The bench's memory model waits a random number of cycles before it answers. Directed walks then fire a control write during the wait and a junk read pulse in the request cycle, and after the result the bench reads the registers back and checks the address. Random walks cover all eight range codes, with table bases and entries that make the shifted result wrap.

// File: rtl/iova_pkg.sv
// Package: shared constants, FSM state type and helper functions for the
// IO virtual address translator. Assumes a 32-bit address space.
package iova_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PTE_BYTES  = 4;
    localparam int BASE_SHIFT = 4;
    localparam int PN_SHIFT   = 4;
    localparam int PN_LSB     = 8;
    localparam int RANGE_W    = 3;
    localparam int RANGE_LSB  = 2;
    localparam int MIN_WIN_LG = 24;
    localparam int PTE_SH     = $clog2(PTE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_st_t;

    // Window start for a range code: all ones above the window size.
    function automatic logic [ADDR_W-1:0] win_start(input logic [RANGE_W-1:0] code);
        return {ADDR_W{1'b1}} << (MIN_WIN_LG + int'(code));
    endfunction

    // Reverse byte order of a 32-bit word.
    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/iova_regfile.sv
// Register window: word-indexed registers relative to BASE_ADDR.
// Assumes reads are combinational and writes take effect at the clock edge
// when wr_allow is high. Register 0 resets to CTRL_RST, others to zero.
module iova_regfile
    import iova_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000_0000,
    parameter int                NUM_REGS  = 4,
    parameter logic [31:0]       CTRL_RST  = 32'h0000_001C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              wr_allow,
    output logic [31:0]       reg_rdata,
    output logic              ctrl_wr,
    output logic [31:0]       tbl_base
);
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int SPAN_B = NUM_REGS * 4;

    logic [ADDR_W-1:0] offs;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       regs_q [NUM_REGS];

    // Decode the window offset into a hit flag and a word index.
    always_comb begin
        offs = reg_addr - BASE_ADDR;
        hit  = (offs < ADDR_W'(SPAN_B));
        idx  = offs[IDX_W+1:2];
    end

    // One storage word per register, full-width write.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [31:0] RST_V = (g == 0) ? CTRL_RST : 32'd0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= RST_V;
            else if (reg_sel && reg_we && wr_allow && hit && (idx == IDX_W'(g)))
                regs_q[g] <= reg_wdata;
        end
    end

    // Read mux: out-of-window addresses read as zero.
    always_comb begin
        reg_rdata = hit ? regs_q[idx] : 32'd0;
    end

    // Strobe for control writes and the table base word.
    always_comb begin
        ctrl_wr  = reg_sel && reg_we && wr_allow && hit && (idx == '0);
        tbl_base = (NUM_REGS > 1) ? regs_q[1 % NUM_REGS] : 32'd0;
    end
endmodule

// File: rtl/iova_window.sv
// Window-start register: recomputed from the range code each time the
// control register is written. Resets to the 2 GB window start.
module iova_window
    import iova_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [31:0]       ctrl_wdata,
    output logic [ADDR_W-1:0] start
);
    logic [ADDR_W-1:0] start_q;

    // Latch the decoded start on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= win_start({RANGE_W{1'b1}});
        else if (ctrl_wr)
            start_q <= win_start(ctrl_wdata[RANGE_LSB +: RANGE_W]);
    end

    assign start = start_q;
endmodule

// File: rtl/iova_walker.sv
// Table walker: accepts one virtual address, issues one entry read, waits
// for data, byte-swaps the entry and produces the physical address.
// Assumes read data arrives no earlier than the cycle after mem_req.
module iova_walker
    import iova_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    input  logic [ADDR_W-1:0] tr_vaddr,
    output logic              tr_ready,
    input  logic [31:0]       tbl_base,
    input  logic [ADDR_W-1:0] start,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_paddr,
    output logic              res_err,
    output logic              idle
);
    walk_st_t              st_q;
    logic [ADDR_W-1:0]     pte_addr_q;
    logic [PAGE_SHIFT-1:0] off_q;
    logic [ADDR_W-1:0]     paddr_q;
    logic                  err_q;
    logic [ADDR_W-1:0]     pte_addr_d;
    logic [31:0]           entry;
    logic [ADDR_W-1:0]     paddr_d;
    logic                  accept;

    // Entry address for the incoming request and result for arriving data.
    always_comb begin
        accept     = (st_q == ST_IDLE) && tr_valid;
        pte_addr_d = (tbl_base << BASE_SHIFT)
                   + (((tr_vaddr - start) >> PAGE_SHIFT) << PTE_SH);
        entry      = bswap32(mem_rdata);
        paddr_d    = ({entry[31:PN_LSB], {PN_LSB{1'b0}}} << PN_SHIFT)
                   + ADDR_W'(off_q);
    end

    // Walk sequence: idle, request, wait for data, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) st_q <= ST_REQ;
                ST_REQ:  st_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request context when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_addr_q <= '0;
            off_q      <= '0;
        end else if (accept) begin
            pte_addr_q <= pte_addr_d;
            off_q      <= tr_vaddr[PAGE_SHIFT-1:0];
        end
    end

    // Capture the translated address and error flag from the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            err_q   <= 1'b0;
        end else if (st_q == ST_WAIT && mem_rvalid) begin
            paddr_q <= paddr_d;
            err_q   <= ~entry[1];
        end
    end

    // Output decode from state.
    always_comb begin
        tr_ready  = (st_q == ST_IDLE);
        idle      = (st_q == ST_IDLE);
        mem_req   = (st_q == ST_REQ);
        mem_addr  = pte_addr_q;
        res_valid = (st_q == ST_DONE);
        res_paddr = paddr_q;
        res_err   = err_q;
    end
endmodule

// File: rtl/iova_xlate.sv
// Top level of the IO virtual address translator: register window,
// window-start decode and the table walker. One walk at a time; register
// writes are refused while a walk is active.
module iova_xlate
    import iova_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int          NUM_REGS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_ready,
    input  logic        tr_valid,
    output logic        tr_ready,
    input  logic [31:0] tr_vaddr,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        res_valid,
    output logic [31:0] res_paddr,
    output logic        res_err
);
    localparam logic [31:0] CTRL_RST = 32'({RANGE_W{1'b1}}) << RANGE_LSB;

    logic        idle;
    logic        ctrl_wr;
    logic [31:0] tbl_base;
    logic [31:0] start;

    iova_regfile #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .CTRL_RST  (CTRL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wr_allow  (idle),
        .reg_rdata (reg_rdata),
        .ctrl_wr   (ctrl_wr),
        .tbl_base  (tbl_base)
    );

    iova_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata),
        .start      (start)
    );

    iova_walker u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tr_valid   (tr_valid),
        .tr_vaddr   (tr_vaddr),
        .tr_ready   (tr_ready),
        .tbl_base   (tbl_base),
        .start      (start),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .res_valid  (res_valid),
        .res_paddr  (res_paddr),
        .res_err    (res_err),
        .idle       (idle)
    );

    // Writes are taken only while no walk is active.
    assign reg_ready = idle;
endmodule

// File: rtl/iova_xlate_chk.sv
// Checker for iova_xlate: handshake and sequencing properties over ports.
module iova_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic tr_valid,
    input logic tr_ready,
    input logic reg_ready,
    input logic mem_req,
    input logic mem_rvalid,
    input logic res_valid
);
    // R1: reset leaves the walker idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !res_valid && tr_ready));

    // R4: an accepted request yields a request next cycle
    p_req_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready) |=> mem_req);

    // R4: request lasts one cycle
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5: result is a single-cycle pulse, followed by idle
    p_res_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && tr_ready));

    // R5: a result only follows sampled read data
    p_res_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mem_rvalid));

    // R7: no acceptance or register writes while busy
    p_busy_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || res_valid) |-> (!tr_ready && !reg_ready));
endmodule

bind iova_xlate iova_xlate_chk u_chk (.*);

// File: tb/tb_iova_xlate.sv
`timescale 1ns/1ps
module tb_iova_xlate;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          NREG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_addr = '0, reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        tr_valid = 1'b0;
    logic        tr_ready;
    logic [31:0] tr_vaddr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic        res_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] sh_ctrl, sh_base;

    always #2.5 clk = ~clk;

    iova_xlate #(.BASE_ADDR(BASE), .NUM_REGS(NREG)) dut (.*);

    function automatic logic [31:0] f_start(input logic [31:0] ctrl);
        return 32'hFFFF_FFFF << (24 + int'(ctrl[4:2]));
    endfunction
    function automatic logic [31:0] f_swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
    function automatic logic [31:0] f_pte(input logic [31:0] b, input logic [31:0] s,
                                          input logic [31:0] va);
        return (b << 4) + (((va - s) >> 12) << 2);
    endfunction
    function automatic logic [31:0] f_pa(input logic [31:0] e, input logic [31:0] va);
        return ((e & 32'hFFFF_FF00) << 4) + {20'd0, va[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
        reg_sel = 1'b0;
    endtask

    // One walk: entry is the logical (swapped) value; lat extra wait cycles.
    task automatic walk(input logic [31:0] va, input logic [31:0] ent, input int lat,
                        input bit poke, input bit junk);
        logic [31:0] ex_a, ex_p;
        ex_a = f_pte(sh_base, f_start(sh_ctrl), va);
        ex_p = f_pa(ent, va);
        @(negedge clk);
        chk(tr_ready == 1'b1, "R7 ready before accept", 32'(tr_ready), 32'd1);
        tr_valid = 1'b1; tr_vaddr = va;
        @(negedge clk);
        tr_valid = 1'b0;
        chk(mem_req == 1'b1, "R4 mem_req", 32'(mem_req), 32'd1);
        chk(mem_addr == ex_a, "R4 mem_addr", mem_addr, ex_a);
        chk(!tr_ready && !reg_ready, "R7 busy", {tr_ready, reg_ready}, 32'd0);
        if (junk) begin
            mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;   // R8 stray pulse in request cycle
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        if (poke) begin
            reg_sel = 1'b1; reg_we = 1'b1; reg_addr = BASE; reg_wdata = 32'h0000_0000;
            chk(reg_ready == 1'b0, "R7 reg_ready low", 32'(reg_ready), 32'd0);
            @(negedge clk);
            reg_sel = 1'b0; reg_we = 1'b0;
        end
        for (int i = 0; i < lat; i++) begin
            chk(!res_valid && !mem_req, "R8 no result while waiting",
                {res_valid, mem_req}, 32'd0);
            @(negedge clk);
        end
        mem_rvalid = 1'b1; mem_rdata = f_swap(ent);
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(res_valid == 1'b1, "R5 res_valid", 32'(res_valid), 32'd1);
        chk(res_paddr == ex_p, "R5 res_paddr", res_paddr, ex_p);
        chk(res_err == ~ent[1], "R6 res_err", 32'(res_err), 32'(~ent[1]));
        chk(tr_ready == 1'b0, "R7 ready low at result", 32'(tr_ready), 32'd0);
        @(negedge clk);
        chk(!res_valid && tr_ready, "R5 single result pulse",
            {res_valid, tr_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] va, ent, sz;
        void'($urandom(32'd20041004));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tr_ready && reg_ready && !mem_req && !res_valid, "R1 reset outputs",
            {tr_ready, reg_ready, mem_req, res_valid}, 32'hC);
        rd_chk(BASE, 32'h0000_001C, "R1 ctrl reset");
        rd_chk(BASE + 4, 32'd0, "R1 base reset");
        sh_ctrl = 32'h0000_001C; sh_base = 32'd0;

        // R3 default 2GB window at reset: first page of 0x80000000 maps to entry 0
        walk(32'h8000_0123, 32'h1234_5602, 0, 1'b0, 1'b0);

        // R2 full-value store, unaligned address, out-of-window ignore
        wr(BASE, 32'hA5A5_A5E0); sh_ctrl = 32'hA5A5_A5E0;
        rd_chk(BASE, 32'hA5A5_A5E0, "R2 ctrl readback");
        wr(BASE + 4 + 3, 32'h0123_4567); sh_base = 32'h0123_4567;
        rd_chk(BASE + 4, 32'h0123_4567, "R2 unaligned hits reg1");
        wr(BASE + 8, 32'h5555_AAAA);
        rd_chk(BASE + 8, 32'h5555_AAAA, "R2 reg2 readback");
        wr(BASE + NREG * 4, 32'hFFFF_FFFF);
        rd_chk(BASE + NREG * 4, 32'd0, "R2 outside window reads 0");
        rd_chk(BASE, 32'hA5A5_A5E0, "R2 outside write ignored ctrl");
        rd_chk(BASE + 4, 32'h0123_4567, "R2 outside write ignored base");
        wr(BASE - 4, 32'hFFFF_FFFF);
        rd_chk(BASE + 8, 32'h5555_AAAA, "R2 below window ignored");

        // R3 code 0 (16MB): start 0xFF000000; R6 invalid entry flags error, bit0 no effect
        wr(BASE, 32'h0000_0000); sh_ctrl = 32'd0;
        walk(32'hFF00_0FFF, 32'hFFFF_FF01, 1, 1'b0, 1'b0);
        walk(32'hFFFF_F000, 32'h0000_0103, 2, 1'b0, 1'b0);

        // R7 write during walk ignored; R8 stray rvalid in request cycle ignored
        walk(32'hFF12_3456, 32'h00AB_CD02, 3, 1'b1, 1'b1);
        rd_chk(BASE, 32'h0000_0000, "R7 ctrl unchanged after blocked write");
        wr(BASE, 32'h0000_0014); sh_ctrl = 32'h14;
        walk(32'hE000_0000, 32'h0000_0002, 0, 1'b1, 1'b0);
        rd_chk(BASE, 32'h0000_0014, "R7 ctrl unchanged (code 5)");

        // R8 stray rvalid while idle produces no result
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = 32'h1111_1111;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(!res_valid && !mem_req && tr_ready, "R8 idle rvalid ignored",
            {res_valid, mem_req, tr_ready}, 32'h1);
        @(negedge clk);
        chk(!res_valid, "R8 idle rvalid no late result", 32'(res_valid), 32'd0);

        // Random walks over all range codes
        for (int k = 0; k < 48; k++) begin
            sh_ctrl = $urandom();
            sh_base = $urandom();
            wr(BASE, sh_ctrl);
            wr(BASE + 4, sh_base);
            sz  = 32'd1 << (24 + int'(sh_ctrl[4:2]));
            va  = f_start(sh_ctrl) | ($urandom() & (sz - 1));
            ent = $urandom();
            walk(va, ent, int'($urandom() % 4), 1'(k % 5 == 0), 1'(k % 7 == 0));
            if (k % 8 == 0) rd_chk(BASE, sh_ctrl, "R3 ctrl random readback");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule